// File: doc/BRIEF.md
# CMOS Clock Register Port and Interrupt Status

This block is the processor-facing side of a CMOS real-time clock. Software reaches it through a two-address bus. A write to the even address picks one of 128 byte locations. An access to the odd address then reads or writes the byte at that location. Most locations are plain byte storage: time bytes that the timekeeping counter owns, and general scratch bytes. Four control locations and three alarm locations behave differently.

The timekeeping counter and the periodic divider sit outside this block and connect through single-cycle strobes:

- an update-start strobe, which marks the beginning of a time update;
- an update-done strobe, which carries the current seconds, minutes and hours bytes;
- a periodic tick.

From these strobes the block keeps the update-in-progress bit and the status flags. It matches the alarm and drives one level-sensitive interrupt line, which stays high until software reads the status register. A device-reset strobe returns the interrupt state to a quiet condition without touching the clock format.

Control locations: A at index 0x0A, B at 0x0B, C at 0x0C, D at 0x0D. Alarm bytes: seconds at 0x01, minutes at 0x03, hours at 0x05.

Register B bits:

| Bit | Meaning |
|-----|---------|
| 7 | SET: freezes updates |
| 6 | Periodic interrupt enable |
| 5 | Alarm interrupt enable |
| 4 | Update interrupt enable |
| 3 | Square-wave enable |

Register C bits:

| Bit | Meaning |
|-----|---------|
| 7 | IRQF: interrupt request summary |
| 6 | PF: periodic flag |
| 5 | AF: alarm flag |
| 4 | UF: update-ended flag |

Top module: `rtc_regport`

## Requirements
- R1: After power-up reset, A reads 0x26, B reads 0x02, C reads 0x00 and D reads 0x80, and `irq` is low.
- R2: An even-address write latches data bits [6:0] as the index, and bit 7 is dropped. An odd-address write stores a byte at the index and an odd-address read returns it. A read at the even address returns 0xFF.
- R3: A write to A changes bits [6:0] only, and bit 7 (UIP) keeps its value. With B.SET clear, an update-start sets UIP and an update-done clears it.
- R4: Writing B with bit 7 set clears UIP. While B.SET is 1, update-start leaves UIP clear and update-done sets no flag.
- R5: Writes to C and D are ignored.
- R6: An update-done with B.SET clear sets UF (C bit 4). Only when B bit 4 is set does it also set IRQF (C bit 7) and raise `irq`.
- R7: `irq` is a level that stays high until C is read. A read of C returns its value, and afterwards C is 0x00 and `irq` is low.
- R8: On update-done, each alarm byte matches when its bits [7:6] are both 1 or when it equals the current byte. A match on all three sets AF (C bit 5), and if B bit 5 is set it also sets IRQF and raises `irq`. A single top bit set is not a wildcard.
- R9: A periodic tick sets PF (C bit 6). If B bit 6 is set it also sets IRQF and raises `irq`.
- R10: The device-reset strobe clears B bits 6, 5 and 3, clears C and lowers `irq`. All other bits of B are kept.
- R11: An event in the same cycle as a read of C is not lost. The read returns the old value, and the new flags and `irq` remain set afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read access |
| dev_rst | input | 1 | Device-reset strobe |
| upd_start | input | 1 | Update-start strobe from the time counter |
| upd_done | input | 1 | Update-done strobe from the time counter |
| per_tick | input | 1 | Periodic-divider tick |
| cur_sec | input | 8 | Current seconds byte, in register encoding |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong flag or enable bit shows up at the ports within a cycle, because it changes both `irq` and the bytes read back from C. Read-to-clear is the sharpest probe. A flag that was never set, or one that fails to clear, shows on the next read of C and in the level of `irq`. That includes the case where an event lands in the same cycle as the read. A corrupted UIP bit or index latch is visible on the very next read of A or of the selected byte.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;

  localparam logic [IDX_W-1:0] IX_ALM_BASE   = 7'h01;
  localparam int               IX_ALM_STRIDE = 2;
  localparam int               ALM_FIELDS    = 3;

  localparam logic [IDX_W-1:0] IX_CTL_A = 7'h0A;
  localparam logic [IDX_W-1:0] IX_CTL_B = 7'h0B;
  localparam logic [IDX_W-1:0] IX_CTL_C = 7'h0C;
  localparam logic [IDX_W-1:0] IX_CTL_D = 7'h0D;

  localparam int A_UIP  = 7;
  localparam int B_SET  = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;
  localparam int B_SQWE = 3;
  localparam int C_IRQF = 7;
  localparam int C_PF   = 6;
  localparam int C_AF   = 5;
  localparam int C_UF   = 4;

  localparam logic [DATA_W-1:0] POR_A = 8'h26;
  localparam logic [DATA_W-1:0] POR_B = 8'h02;
  localparam logic [DATA_W-1:0] POR_D = 8'h80;
  localparam logic [DATA_W-1:0] DEVRST_B_CLR =
    (8'h1 << B_PIE) | (8'h1 << B_AIE) | (8'h1 << B_SQWE);

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } reg_acc_t;
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output reg_acc_t          acc
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = bus_sel & bus_we & ~bus_addr;

  always_comb begin
    idx_d = idx_q;
    if (idx_en) idx_d = bus_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign acc.wr   = bus_sel & bus_we & bus_addr;
  assign acc.rd   = bus_sel & ~bus_we & bus_addr;
  assign acc.idx  = idx_q;
  assign acc.data = bus_wdata;

  // R2: the index changes only through an even-address write
  a_r2_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_en |=> idx_q == $past(idx_q));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_regport_pkg::*;
#(
  parameter int FIELDS = ALM_FIELDS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [FIELDS*DATA_W-1:0] cur_time,
  output logic                     idx_hit,
  output logic [DATA_W-1:0]        rd_byte,
  output logic                     all_match
);
  logic [FIELDS-1:0]        sel_vec;
  logic [FIELDS-1:0]        field_ok;
  logic [FIELDS*DATA_W-1:0] alm_flat;

  for (genvar gi = 0; gi < FIELDS; gi++) begin : g_field
    localparam logic [IDX_W-1:0] FIELD_IX = IX_ALM_BASE + IDX_W'(IX_ALM_STRIDE * gi);
    logic [DATA_W-1:0] alm_q, alm_d;
    logic [DATA_W-1:0] now_b;

    assign sel_vec[gi] = (wr_idx == FIELD_IX);
    assign now_b       = cur_time[gi*DATA_W +: DATA_W];

    always_comb begin
      alm_d = alm_q;
      if (wr_en && sel_vec[gi]) alm_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_q <= '0;
      else        alm_q <= alm_d;
    end

    assign field_ok[gi] = (alm_q[DATA_W-1 -: 2] == 2'b11) || (alm_q == now_b);
    assign alm_flat[gi*DATA_W +: DATA_W] = alm_q;
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < FIELDS; k++)
      if (sel_vec[k]) rd_byte = alm_flat[k*DATA_W +: DATA_W];
  end

  assign idx_hit   = |sel_vec;
  assign all_match = &field_ok;

  // R8: at most one alarm field is addressed at a time
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
  import rtc_regport_pkg::*;
#(
  parameter int AW = IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  reg_acc_t          acc,
  input  logic              dev_rst,
  input  logic              upd_start,
  input  logic              upd_done,
  input  logic              per_tick,
  input  logic              alarm_hit,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] reg_c,
  output logic [DATA_W-1:0] reg_d,
  output logic              irq
);
  logic              uip_q, uip_d;
  logic [6:0]        a_lo_q, a_lo_d;
  logic [DATA_W-1:0] b_q, b_d;
  logic [3:0]        c_q, c_d;
  logic              irq_q, irq_d;
  logic              wr_a, wr_b, wr_c, rd_c, frozen;
  logic              ev_uf, ev_af, ev_pf, raise;
  logic [3:0]        c_new;

  assign wr_a   = acc.wr && (acc.idx == IX_CTL_A);
  assign wr_b   = acc.wr && (acc.idx == IX_CTL_B);
  assign wr_c   = acc.wr && (acc.idx == IX_CTL_C);
  assign rd_c   = acc.rd && (acc.idx == IX_CTL_C);
  assign frozen = b_q[B_SET];

  assign ev_uf = upd_done & ~frozen;
  assign ev_af = ev_uf & alarm_hit;
  assign ev_pf = per_tick;
  assign raise = (ev_uf & b_q[B_UIE]) | (ev_af & b_q[B_AIE]) | (ev_pf & b_q[B_PIE]);
  assign c_new = {raise, ev_pf, ev_af, ev_uf};

  always_comb begin
    uip_d = uip_q;
    if (wr_b && acc.data[B_SET])   uip_d = 1'b0;
    else if (upd_done)             uip_d = 1'b0;
    else if (upd_start && !frozen) uip_d = 1'b1;

    a_lo_d = wr_a ? acc.data[6:0] : a_lo_q;

    b_d = wr_b ? acc.data : b_q;
    if (dev_rst) b_d = b_d & ~DEVRST_B_CLR;

    c_d   = (rd_c ? 4'h0 : c_q) | c_new;
    irq_d = (rd_c ? 1'b0 : irq_q) | raise;
    if (dev_rst) begin
      c_d   = 4'h0;
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uip_q  <= POR_A[A_UIP];
      a_lo_q <= POR_A[6:0];
      b_q    <= POR_B;
      c_q    <= 4'h0;
      irq_q  <= 1'b0;
    end else begin
      uip_q  <= uip_d;
      a_lo_q <= a_lo_d;
      b_q    <= b_d;
      c_q    <= c_d;
      irq_q  <= irq_d;
    end
  end

  assign reg_a = {uip_q, a_lo_q};
  assign reg_b = b_q;
  assign reg_c = {c_q, 4'h0};
  assign reg_d = POR_D;
  assign irq   = irq_q;

  a_r3_uip_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !upd_start && !upd_done) |=> reg_a[A_UIP] == $past(reg_a[A_UIP]));
  a_r4_set_clears_uip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && acc.data[B_SET]) |=> !reg_a[A_UIP]);
  a_r5_c_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !upd_done && !per_tick && !dev_rst) |=> reg_c == $past(reg_c));
  a_r6_uf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !frozen && !dev_rst) |=> reg_c[C_UF]);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !upd_done && !per_tick) |=> (reg_c == 8'h00) && !irq);
  a_r9_pf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tick && !dev_rst) |=> reg_c[C_PF]);
  a_r10_devrst: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> (reg_c == 8'h00) && !irq && ((reg_b & DEVRST_B_CLR) == 8'h00));
  a_r7_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reg_c[C_IRQF]);
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       dev_rst,
  input  logic       upd_start,
  input  logic       upd_done,
  input  logic       per_tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  output logic       irq
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  reg_acc_t          acc;
  logic              alm_idx_hit, alm_match, ctl_idx_hit, store_we;
  logic [DATA_W-1:0] alm_byte, store_byte, ra, rb, rc, rd, sel_byte;

  rtc_bus_decode u_dec (
    .clk(clk), .rst_n(rst_s_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .acc(acc)
  );

  rtc_alarm_match #(.FIELDS(ALM_FIELDS)) u_alm (
    .clk(clk), .rst_n(rst_s_n), .wr_en(acc.wr), .wr_idx(acc.idx),
    .wr_data(acc.data), .cur_time({cur_hour, cur_min, cur_sec}),
    .idx_hit(alm_idx_hit), .rd_byte(alm_byte), .all_match(alm_match)
  );

  rtc_ctrl_regs u_ctl (
    .clk(clk), .rst_n(rst_s_n), .acc(acc), .dev_rst(dev_rst),
    .upd_start(upd_start), .upd_done(upd_done), .per_tick(per_tick),
    .alarm_hit(alm_match), .reg_a(ra), .reg_b(rb), .reg_c(rc), .reg_d(rd),
    .irq(irq)
  );

  assign ctl_idx_hit = (acc.idx >= IX_CTL_A) && (acc.idx <= IX_CTL_D);
  assign store_we    = acc.wr && !ctl_idx_hit && !alm_idx_hit;

  rtc_byte_store #(.AW(IDX_W)) u_store (
    .clk(clk), .we(store_we), .addr(acc.idx), .wdata(acc.data),
    .rdata(store_byte)
  );

  always_comb begin
    unique case (1'b1)
      (acc.idx == IX_CTL_A): sel_byte = ra;
      (acc.idx == IX_CTL_B): sel_byte = rb;
      (acc.idx == IX_CTL_C): sel_byte = rc;
      (acc.idx == IX_CTL_D): sel_byte = rd;
      alm_idx_hit:           sel_byte = alm_byte;
      default:               sel_byte = store_byte;
    endcase
  end

  assign bus_rdata = bus_addr ? sel_byte : 8'hFF;
endmodule

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_we, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       dev_rst, upd_start, upd_done, per_tick;
  logic [7:0] cur_sec, cur_min, cur_hour;
  logic       irq;
  int         n_checks = 0;
  int         n_errors = 0;
  logic       finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_rst(dev_rst), .upd_start(upd_start), .upd_done(upd_done),
    .per_tick(per_tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .irq(irq)
  );

  localparam logic [6:0] IA = 7'h0A, IB = 7'h0B, IC = 7'h0C, ID = 7'h0D;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic addr, input logic [7:0] d,
                     output logic [7:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = d;
    #1 q = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wreg(input logic [6:0] ix, input logic [7:0] v);
    logic [7:0] q;
    bus(1'b1, 1'b0, {1'b0, ix}, q);
    bus(1'b1, 1'b1, v, q);
  endtask

  task automatic rreg(input logic [6:0] ix, output logic [7:0] v);
    logic [7:0] q;
    bus(1'b1, 1'b0, {1'b0, ix}, q);
    bus(1'b0, 1'b1, 8'h00, v);
  endtask

  task automatic expect_reg(input string req, input logic [6:0] ix, input logic [7:0] exp);
    logic [7:0] v;
    rreg(ix, v);
    check(req, v, exp);
  endtask

  task automatic expect_irq(input string req, input logic exp);
    @(negedge clk);
    check(req, {7'h0, irq}, {7'h0, exp});
  endtask

  task automatic pulse_start();
    @(negedge clk); upd_start = 1'b1; @(posedge clk); #1 upd_start = 1'b0;
  endtask
  task automatic pulse_done();
    @(negedge clk); upd_done = 1'b1; @(posedge clk); #1 upd_done = 1'b0;
  endtask
  task automatic pulse_tick();
    @(negedge clk); per_tick = 1'b1; @(posedge clk); #1 per_tick = 1'b0;
  endtask
  task automatic pulse_devrst();
    @(negedge clk); dev_rst = 1'b1; @(posedge clk); #1 dev_rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] q;
    expect_irq("R1 irq", 1'b0);
    expect_reg("R1 A", IA, 8'h26);
    expect_reg("R1 B", IB, 8'h02);
    expect_reg("R1 C", IC, 8'h00);
    expect_reg("R1 D", ID, 8'h80);
    bus(1'b0, 1'b0, 8'h00, q);
    check("R2 even read", q, 8'hFF);
  endtask

  task automatic t_index();
    logic [7:0] q;
    bus(1'b1, 1'b0, 8'h8E, q);
    bus(1'b1, 1'b1, 8'h5A, q);
    bus(1'b1, 1'b0, 8'h0E, q);
    bus(1'b0, 1'b1, 8'h00, q);
    check("R2 index bit7 dropped", q, 8'h5A);
    wreg(7'h40, 8'hC3);
    expect_reg("R2 byte 0x40", 7'h40, 8'hC3);
    expect_reg("R2 byte 0x0E kept", 7'h0E, 8'h5A);
  endtask

  task automatic t_uip();
    wreg(IA, 8'hFF);
    expect_reg("R3 A write keeps UIP", IA, 8'h7F);
    pulse_start();
    expect_reg("R3 start sets UIP", IA, 8'hFF);
    wreg(IA, 8'h26);
    expect_reg("R3 write under UIP", IA, 8'hA6);
    pulse_done();
    expect_reg("R3 done clears UIP", IA, 8'h26);
    expect_irq("R6 no irq without UIE", 1'b0);
    expect_reg("R6 UF only", IC, 8'h10);
  endtask

  task automatic t_set();
    pulse_start();
    wreg(IB, 8'h82);
    expect_reg("R4 SET clears UIP", IA, 8'h26);
    pulse_start();
    expect_reg("R4 start frozen", IA, 8'h26);
    pulse_done();
    expect_reg("R4 done frozen", IC, 8'h00);
    wreg(IB, 8'h02);
  endtask

  task automatic t_readonly();
    wreg(IC, 8'hFF);
    wreg(ID, 8'h00);
    expect_irq("R5 irq", 1'b0);
    expect_reg("R5 C ignored", IC, 8'h00);
    expect_reg("R5 D ignored", ID, 8'h80);
  endtask

  task automatic t_uf_irq();
    wreg(IB, 8'h12);
    pulse_done();
    expect_irq("R6 irq raised", 1'b1);
    repeat (5) @(posedge clk);
    expect_irq("R7 irq level held", 1'b1);
    expect_reg("R7 read C value", IC, 8'h90);
    expect_irq("R7 irq dropped", 1'b0);
    expect_reg("R7 C cleared", IC, 8'h00);
  endtask

  task automatic t_alarm();
    wreg(7'h01, 8'h30); wreg(7'h03, 8'hC0); wreg(7'h05, 8'h12);
    expect_reg("R8 alarm readback", 7'h03, 8'hC0);
    wreg(IB, 8'h22);
    cur_sec = 8'h30; cur_min = 8'h45; cur_hour = 8'h12;
    pulse_done();
    expect_irq("R8 alarm irq", 1'b1);
    expect_reg("R8 match wildcard", IC, 8'hB0);
    cur_sec = 8'h31;
    pulse_done();
    expect_irq("R8 mismatch no irq", 1'b0);
    expect_reg("R8 mismatch", IC, 8'h10);
    cur_sec = 8'h30;
    wreg(7'h03, 8'h80);
    pulse_done();
    expect_reg("R8 single top bit not wild", IC, 8'h10);
    wreg(7'h03, 8'h45);
    pulse_done();
    expect_reg("R8 exact match", IC, 8'hB0);
    wreg(IB, 8'h02);
    pulse_done();
    expect_irq("R8 AIE off irq", 1'b0);
    expect_reg("R8 AIE off flags", IC, 8'h30);
    cur_sec = 8'h31;
  endtask

  task automatic t_periodic();
    pulse_tick();
    expect_irq("R9 no PIE irq", 1'b0);
    expect_reg("R9 PF only", IC, 8'h40);
    wreg(IB, 8'h42);
    pulse_tick();
    expect_irq("R9 PIE irq", 1'b1);
    expect_reg("R9 PF+IRQF", IC, 8'hC0);
  endtask

  task automatic t_devrst();
    wreg(IB, 8'h7A);
    pulse_tick();
    expect_irq("R10 irq before", 1'b1);
    pulse_devrst();
    expect_irq("R10 irq lowered", 1'b0);
    expect_reg("R10 B masked", IB, 8'h12);
    expect_reg("R10 C cleared", IC, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] q;
    bus(1'b1, 1'b0, {1'b0, IC}, q);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 1'b1; upd_done = 1'b1;
    #1 q = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0; upd_done = 1'b0;
    check("R11 read returns old", q, 8'h00);
    expect_irq("R11 irq kept", 1'b1);
    expect_reg("R11 flags kept", IC, 8'h90);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 1'b0;
    bus_wdata = 8'h00; dev_rst = 1'b0; upd_start = 1'b0; upd_done = 1'b0;
    per_tick = 1'b0; cur_sec = 8'h11; cur_min = 8'h22; cur_hour = 8'h03;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_index();
    t_uip();
    t_set();
    t_readonly();
    t_uf_irq();
    t_alarm();
    t_periodic();
    t_devrst();
    t_race();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule